// File: doc/BRIEF.md
# Prescaled Watchdog Timer

This block is a watchdog that supervises a processor. An instruction-cycle strobe, which the clock generator raises once per twelve oscillator clocks, drives a power-of-two prescaler. The prescaler drives a wide timer, 14 bits by default. When the timer wraps, the block sets a sticky time-out flag. If the enable bit is set, it also raises a reset request for one clock.

Software controls the block through one control byte. It writes the byte through a write strobe and can read it back at any time. To restart the watchdog, software writes the clear bit. That bit clears the prescaler, the timer and the flag on the next instruction cycle, and then returns to 0. A separate bit decides whether counting continues while the processor is idle.

The block has no data stream, so it has no valid/ready handshake. Every pin is a plain level or strobe, sampled on the rising clock edge.

Top module: `prescaled_wdt`

## Requirements
- R1: After `rst_n` is released, the control byte reads 0x00, and `tmo_flag_o` and `wdt_rst_o` are low.
- R2: The control byte uses these bit positions: bit 7 is enable, bit 6 is clear, bit 5 is run-in-idle, and bits 2..0 are the prescale code PS. Bits 4..3 always read 0. A write takes effect at the clock edge that samples `cfg_we_i`.
- R3: The prescale ratio is 2^(PS+1), so code 0 gives 2 and code 7 gives 256. A time-out occurs on the (2^(PS+1) × 2^TMR_W)-th counted strobe after a clear.
- R4: `tmo_flag_o` rises at the edge where the time-out occurs. It stays high until a clear or a reset.
- R5: At a time-out, `wdt_rst_o` is high for exactly one clock, and only when the enable bit was set. Counting restarts from zero, so the next time-out needs another full period.
- R6: A 1 written to the clear bit reads back as 1 until the next strobe. On that strobe the prescaler, the timer and the flag are cleared, the bit returns to 0, and the strobe is not counted.
- R7: While `idle_i` is high and run-in-idle is 0, strobes are not counted. With run-in-idle set, they are counted.
- R8: Clock cycles with `tick_i` low do not advance the count.
- R9: `ext_rst_i` high at an edge clears the control byte, the count, the flag and the reset request at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Instruction-cycle strobe, one clock wide |
| idle_i | input | 1 | Processor is in idle mode |
| ext_rst_i | input | 1 | Synchronous external reset, active high |
| cfg_we_i | input | 1 | Control byte write strobe |
| cfg_wdata_i | input | 8 | Control byte write data |
| cfg_rdata_o | output | 8 | Control byte read value |
| tmo_flag_o | output | 1 | Sticky time-out flag |
| wdt_rst_o | output | 1 | One-clock reset request |

## Verification
Every result is registered and appears one edge after the stimulus that causes it. A control write shows on `cfg_rdata_o` after the sampling edge. The flag and the reset request appear after the edge that takes the last counted strobe, and the reset request falls one edge later. The bench drives inputs at the falling edge, steps a cycle model at the rising edge, and compares all outputs 2 ns after that edge. This places every comparison in the first cycle a result may legally show.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int PS_W = 3;

  typedef struct packed {
    logic            en;        // bit 7
    logic            clr;       // bit 6
    logic            idle_run;  // bit 5
    logic [1:0]      rsvd;      // bits 4..3, read 0
    logic [PS_W-1:0] ps;        // bits 2..0
  } wdt_cfg_t;

  localparam logic [7:0] CFG_WMASK = 8'hE7;
endpackage

// File: rtl/wdt_cfg_reg.sv
module wdt_cfg_reg
  import wdt_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     ext_rst_i,
  input  logic     tick_i,
  input  logic     we_i,
  input  logic [7:0] wdata_i,
  output wdt_cfg_t cfg_o
);
  wdt_cfg_t cfg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
    end else if (ext_rst_i) begin
      cfg_q <= '0;
    end else if (we_i) begin
      cfg_q <= wdt_cfg_t'(wdata_i & CFG_WMASK);
    end else if (tick_i && cfg_q.clr) begin
      cfg_q.clr <= 1'b0;
    end
  end

  assign cfg_o = cfg_q;

  // R6
  clrw_self_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_q.clr && tick_i && !we_i) |=> !cfg_q.clr);

  // R9
  ext_clear_cfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ext_rst_i |=> (cfg_q == '0));
endmodule

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
  parameter int PS_W = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr_i,
  input  logic            step_i,
  input  logic [PS_W-1:0] ps_i,
  output logic            carry_o
);
  localparam int PRE_W = 2 ** PS_W;

  logic [PRE_W-1:0] cnt_q;
  logic [PRE_W-1:0] lim;

  always_comb begin
    lim = '0;
    for (int i = 0; i < PRE_W; i++) begin
      if (i <= int'(ps_i)) lim[i] = 1'b1;
    end
  end

  assign carry_o = step_i && (cnt_q >= lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (clr_i) begin
      cnt_q <= '0;
    end else if (carry_o) begin
      cnt_q <= '0;
    end else if (step_i) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // R8
  pre_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!step_i && !clr_i) |=> $stable(cnt_q));

  // R6
  pre_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (cnt_q == '0));
endmodule

// File: rtl/wdt_timer.sv
module wdt_timer #(
  parameter int TMR_W = 14
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic inc_i,
  output logic ovf_o
);
  logic [TMR_W-1:0] cnt_q;

  assign ovf_o = inc_i && (&cnt_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (clr_i) begin
      cnt_q <= '0;
    end else if (inc_i) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // R5
  ovf_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_o |=> (cnt_q == '0));
endmodule

// File: rtl/prescaled_wdt.sv
module prescaled_wdt
  import wdt_pkg::*;
#(
  parameter int TMR_W = 14
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_i,
  input  logic       idle_i,
  input  logic       ext_rst_i,
  input  logic       cfg_we_i,
  input  logic [7:0] cfg_wdata_i,
  output logic [7:0] cfg_rdata_o,
  output logic       tmo_flag_o,
  output logic       wdt_rst_o
);
  wdt_cfg_t cfg;
  logic     clr, step, carry, ovf;
  logic     flag_q, rst_q;

  wdt_cfg_reg u_cfg (
    .clk       (clk),
    .rst_n     (rst_n),
    .ext_rst_i (ext_rst_i),
    .tick_i    (tick_i),
    .we_i      (cfg_we_i),
    .wdata_i   (cfg_wdata_i),
    .cfg_o     (cfg)
  );

  assign clr  = ext_rst_i || (tick_i && cfg.clr);
  assign step = tick_i && !cfg.clr && !ext_rst_i && !(idle_i && !cfg.idle_run);

  wdt_prescaler #(.PS_W(PS_W)) u_pre (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr_i   (clr),
    .step_i  (step),
    .ps_i    (cfg.ps),
    .carry_o (carry)
  );

  wdt_timer #(.TMR_W(TMR_W)) u_tmr (
    .clk   (clk),
    .rst_n (rst_n),
    .clr_i (clr),
    .inc_i (carry),
    .ovf_o (ovf)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      rst_q  <= 1'b0;
    end else begin
      rst_q <= ovf && cfg.en;
      if (clr)      flag_q <= 1'b0;
      else if (ovf) flag_q <= 1'b1;
    end
  end

  assign cfg_rdata_o = cfg;
  assign tmo_flag_o  = flag_q;
  assign wdt_rst_o   = rst_q;

  // R5
  rst_pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_rst_o |=> !wdt_rst_o);

  // R5
  rst_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wdt_rst_o) |-> $past(cfg.en));

  // R4
  rst_with_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_rst_o |-> tmo_flag_o);

  // R4
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tmo_flag_o && !clr) |=> tmo_flag_o);
endmodule

// File: tb/prescaled_wdt_bench.sv
module prescaled_wdt_bench;
  localparam int TW = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tk = 1'b0, idl = 1'b0, xr = 1'b0, we = 1'b0;
  logic [7:0] wd = '0;
  logic [7:0] rdata;
  logic flag, rsto;

  int tests = 0, fails = 0, cycles = 0;

  logic [7:0] m_ctl = '0;
  int unsigned m_cnt = 0;
  bit m_flag = 0, m_rst = 0;

  always #10 clk = ~clk;

  prescaled_wdt #(.TMR_W(TW)) u_prescaled_wdt (
    .clk(clk), .rst_n(rst_n), .tick_i(tk), .idle_i(idl), .ext_rst_i(xr),
    .cfg_we_i(we), .cfg_wdata_i(wd), .cfg_rdata_o(rdata),
    .tmo_flag_o(flag), .wdt_rst_o(rsto)
  );

  function automatic int unsigned period(logic [2:0] ps);
    return (32'd1 << (ps + 1)) * (32'd1 << TW);
  endfunction

  task automatic check(string tag, string what, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic model();
    logic [7:0] old;
    old = m_ctl;
    if (xr) begin
      m_ctl = '0; m_cnt = 0; m_flag = 0; m_rst = 0;
    end else begin
      m_rst = 0;
      if (tk && old[6]) begin
        m_cnt = 0; m_flag = 0;
      end else if (tk && !(idl && !old[5])) begin
        m_cnt++;
        if (m_cnt == period(old[2:0])) begin
          m_cnt = 0; m_flag = 1; m_rst = old[7];
        end
      end
      if (we) m_ctl = wd & 8'hE7;
      else if (tk && old[6]) m_ctl[6] = 1'b0;
    end
  endtask

  // one clock: inputs already set; step model at edge, compare after it
  task automatic step(string tag);
    @(posedge clk);
    model();
    #2;
    check(tag, "cfg_rdata", rdata, m_ctl);
    check(tag, "tmo_flag", flag, m_flag);
    check(tag, "wdt_rst", rsto, m_rst);
    @(negedge clk);
    we = 0; xr = 0;
  endtask

  task automatic write(logic [7:0] v, string tag);
    we = 1; wd = v; tk = 0; step(tag);
  endtask

  task automatic ticks(int n, string tag);
    tk = 1;
    for (int i = 0; i < n; i++) step(tag);
    tk = 0;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 200000) begin
      fails++;
      tests++;
      $display("FAIL watchdog expired actual=%0d expected<200000", cycles);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    @(negedge clk);
    // R1: reset state
    #2;
    check("R1", "rdata in reset", rdata, 0);
    check("R1", "flag in reset", flag, 0);
    rst_n = 1;
    step("R1");

    // R2: reserved bits masked, layout read back
    write(8'hFF, "R2");
    check("R2", "masked readback", rdata, 8'hE7);
    // R6: clear bit pends until a strobe
    step("R6");
    check("R6", "clr pending", rdata[6], 1);
    ticks(1, "R6");
    check("R6", "clr self cleared", rdata[6], 0);

    // R3 R5: period per prescale code, reset pulse when enabled
    for (int ps = 0; ps < 4; ps++) begin
      write(8'hC0 | ps, "R3");
      ticks(1, "R6");
      ticks(period(ps) - 1, "R3");
      check("R3", "no early timeout", flag, 0);
      ticks(1, "R3");
      check("R4", "flag at timeout", flag, 1);
      check("R5", "reset pulse", rsto, 1);
      step("R5");
      check("R5", "pulse one clock", rsto, 0);
    end

    // R5: disabled watchdog sets flag only; restart gives a full period again
    write(8'h40, "R5");
    ticks(1, "R6");
    ticks(period(0), "R5");
    check("R5", "flag without enable", flag, 1);
    check("R5", "no reset when off", rsto, 0);
    ticks(period(0), "R5");
    check("R4", "flag stays high", flag, 1);

    // R7: idle gating
    write(8'hC0, "R7");
    ticks(1, "R6");
    idl = 1;
    ticks(period(0) + 10, "R7");
    check("R7", "no count in idle", flag, 0);
    write(8'hA0, "R7");
    ticks(period(0), "R7");
    check("R7", "count in idle when allowed", flag, 1);
    idl = 0;

    // R8: no strobe, no count
    write(8'hC0, "R8");
    ticks(1, "R6");
    ticks(period(0) - 1, "R8");
    for (int i = 0; i < 50; i++) step("R8");
    check("R8", "idle clocks ignored", flag, 0);
    ticks(1, "R8");
    check("R8", "timeout on last strobe", rsto, 1);

    // R9: external reset
    xr = 1; step("R9");
    check("R9", "ctl cleared", rdata, 0);
    check("R9", "flag cleared", flag, 0);

    // random phase
    for (int c = 0; c < 30000; c++) begin
      tk  = ($urandom % 10) < 7;
      idl = ($urandom % 10) < 2;
      xr  = ($urandom % 3000) == 0;
      we  = ($urandom % 400) == 0;
      if (we) begin
        if (m_ctl[6] || ($urandom % 2)) wd = {$urandom % 2 == 1, 1'b1, $urandom % 2 == 1, 2'($urandom), 3'($urandom)};
        else wd = {$urandom % 2 == 1, 1'b0, $urandom % 2 == 1, 2'($urandom), m_ctl[2:0]};
        tk = 0;
      end
      step("R3");
    end

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule